// File: doc/BRIEF.md
# Two-Line Maskable Interrupt Router

This block gathers a set of level-sensitive hardware interrupt requests and one request that software raises itself. It presents them to a processor on two active-low request lines: a normal line and a fast line. A small register bus gives software three things:

- a read-only status word that shows every source currently asserting;
- a per-source mask;
- a per-source routing choice between the two lines.

Hardware requests carry no stored state in the router. They stay visible only for as long as the peripheral holds them. The software request is a stored bit, set and cleared through two dedicated write addresses. Both request lines are flopped and recomputed every cycle from status, mask and routing. Software may therefore reprogram mask or routing while requests are pending without producing a glitch on either line.

Registers, all on a 32-bit data bus:

| Address | Access | Contents |
|---|---|---|
| 0x00 | read-only | status |
| 0x04 | read/write | mask |
| 0x08 | read/write | routing |
| 0x0C | write-only | software set |
| 0x10 | write-only | software clear |

Bit i, for i below NUM_SRC, belongs to hardware source i. Bit NUM_SRC belongs to the software source.

Top module: `dual_line_intc`

## Requirements
- R1: After reset, both request lines are high, the mask is all ones, routing is all zeros, the software bit is clear and read data is zero.
- R2: A read of address 0x00 returns the hardware sources in bits NUM_SRC-1..0 and the software bit in bit NUM_SRC, with zeros above. The mask has no effect on this value.
- R3: A write to 0x04 loads the mask from write data bits NUM_SRC..0, and a read of 0x04 returns it. A mask bit of 1 keeps that source off both lines.
- R4: A write to 0x08 loads routing from write data bits NUM_SRC..0, and a read of 0x08 returns it. Routing bit 1 sends the source to the fast line; routing bit 0 sends it to the normal line.
- R5: `irq_n` is low in the cycle after a clock edge at which some source is active, unmasked and routed with bit 0. Otherwise `irq_n` is high.
- R6: `fiq_n` is low in the cycle after a clock edge at which some source is active, unmasked and routed with bit 1. Otherwise `fiq_n` is high.
- R7: A write to 0x0C with write data bit 0 equal to 1 sets the software bit. With bit 0 equal to 0, the write has no effect.
- R8: A write to 0x10 with write data bit 0 equal to 1 clears the software bit. With bit 0 equal to 0, the write has no effect.
- R9: Writes to 0x00 or to any unmapped address change neither mask, routing nor the software bit.
- R10: A hardware source holds nothing. Its request line rises again the cycle after the source drops, when no other source drives that line.
- R11: Read data appears the cycle after a read strobe and holds until the next read. Reads of 0x0C, 0x10 or any unmapped address return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Level-sensitive hardware requests, active high |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_n | output | 1 | Normal request line, active low |
| fiq_n | output | 1 | Fast request line, active low |

## Verification
A corrupted mask, routing or software bit shows up one cycle later: a request line sits at the wrong level while an affected source is active. The same fault appears in the next read of 0x04, 0x08 or 0x00. A router that wrongly retained a hardware request would leave a line low one cycle after the source dropped. The reference model compares both lines and the read data on every cycle, under mixed traffic: mask and routing rewrites while requests are pending, software set and clear, and writes to read-only or unmapped addresses.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] ADR_STATUS = 5'h00;
    localparam logic [ADDR_W-1:0] ADR_MASK   = 5'h04;
    localparam logic [ADDR_W-1:0] ADR_ROUTE  = 5'h08;
    localparam logic [ADDR_W-1:0] ADR_SWSET  = 5'h0C;
    localparam logic [ADDR_W-1:0] ADR_SWCLR  = 5'h10;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_READ,
        OP_WR_MASK,
        OP_WR_ROUTE,
        OP_WR_SET,
        OP_WR_CLR,
        OP_WR_NONE
    } bus_op_e;

    function automatic bus_op_e decode_op(input logic sel, input logic wr,
                                          input logic [ADDR_W-1:0] addr);
        bus_op_e op;
        if (!sel)     op = OP_IDLE;
        else if (!wr) op = OP_READ;
        else begin
            case (addr)
                ADR_MASK:  op = OP_WR_MASK;
                ADR_ROUTE: op = OP_WR_ROUTE;
                ADR_SWSET: op = OP_WR_SET;
                ADR_SWCLR: op = OP_WR_CLR;
                default:   op = OP_WR_NONE;
            endcase
        end
        return op;
    endfunction
endpackage

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
    import irq_steer_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int TOT = NUM_SRC + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [TOT-1:0]    status_o,
    output logic [TOT-1:0]    mask_o,
    output logic [TOT-1:0]    route_o,
    output logic [DATA_W-1:0] rdata_o
);
    typedef struct packed {
        logic [TOT-1:0]    mask;
        logic [TOT-1:0]    route;
        logic              sw;
        logic [DATA_W-1:0] rdata;
    } bank_t;

    bank_t   bank_d, bank_q;
    bus_op_e op;
    logic [DATA_W-1:0] rd_val;

    assign status_o = {bank_q.sw, src_i};

    always_comb begin
        op     = decode_op(bus_sel, bus_wr, bus_addr);
        bank_d = bank_q;
        case (bus_addr)
            ADR_STATUS: rd_val = DATA_W'(status_o);
            ADR_MASK:   rd_val = DATA_W'(bank_q.mask);
            ADR_ROUTE:  rd_val = DATA_W'(bank_q.route);
            default:    rd_val = '0;
        endcase
        case (op)
            OP_READ:     bank_d.rdata = rd_val;
            OP_WR_MASK:  bank_d.mask  = bus_wdata[TOT-1:0];
            OP_WR_ROUTE: bank_d.route = bus_wdata[TOT-1:0];
            OP_WR_SET:   if (bus_wdata[0]) bank_d.sw = 1'b1;
            OP_WR_CLR:   if (bus_wdata[0]) bank_d.sw = 1'b0;
            default:     ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q.mask  <= '1;
            bank_q.route <= '0;
            bank_q.sw    <= 1'b0;
            bank_q.rdata <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign mask_o  = bank_q.mask;
    assign route_o = bank_q.route;
    assign rdata_o = bank_q.rdata;

    // R3
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADR_MASK) |=> (mask_o == $past(bus_wdata[TOT-1:0])));
    // R7
    sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADR_SWSET && bus_wdata[0]) |=> status_o[NUM_SRC]);
    // R8
    sw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADR_SWCLR && bus_wdata[0]) |=> !status_o[NUM_SRC]);
    // R9
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADR_STATUS)
        |=> ($stable(mask_o) && $stable(route_o) && $stable(status_o[NUM_SRC])));
    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> $stable(rdata_o));
endmodule

// File: rtl/irq_line_drive.sv
module irq_line_drive #(
    parameter int TOT = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [TOT-1:0] status_i,
    input  logic [TOT-1:0] mask_i,
    input  logic [TOT-1:0] route_i,
    output logic           irq_n_o,
    output logic           fiq_n_o
);
    typedef struct packed {
        logic irq_n;
        logic fiq_n;
    } line_t;

    line_t line_d, line_q;
    logic [TOT-1:0] to_norm, to_fast;

    for (genvar i = 0; i < TOT; i++) begin : g_src
        assign to_norm[i] = status_i[i] & ~mask_i[i] & ~route_i[i];
        assign to_fast[i] = status_i[i] & ~mask_i[i] &  route_i[i];
    end

    always_comb begin
        line_d.irq_n = ~(|to_norm);
        line_d.fiq_n = ~(|to_fast);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '{irq_n: 1'b1, fiq_n: 1'b1};
        else        line_q <= line_d;
    end

    assign irq_n_o = line_q.irq_n;
    assign fiq_n_o = line_q.fiq_n;

    // R5
    norm_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status_i & ~mask_i & ~route_i)) |=> !irq_n_o);
    // R6
    fast_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(status_i & ~mask_i & route_i)) |=> fiq_n_o);
endmodule

// File: rtl/dual_line_intc.sv
module dual_line_intc
    import irq_steer_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [4:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_n,
    output logic               fiq_n
);
    localparam int TOT = NUM_SRC + 1;

    logic [TOT-1:0] status, mask, route;

    irq_reg_bank #(.NUM_SRC(NUM_SRC)) u_bank (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .status_o(status), .mask_o(mask),
        .route_o(route), .rdata_o(bus_rdata)
    );

    irq_line_drive #(.TOT(TOT)) u_drive (
        .clk(clk), .rst_n(rst_n), .status_i(status), .mask_i(mask),
        .route_i(route), .irq_n_o(irq_n), .fiq_n_o(fiq_n)
    );

    // R3
    all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |=> (irq_n && fiq_n));
    // R10
    src_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|src_i) && !status[NUM_SRC]) |=> (irq_n && fiq_n));
endmodule

// File: tb/tb_dual_line_intc.sv
module tb_dual_line_intc;
    localparam int N   = 8;
    localparam int TOT = N + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src = '0;
    logic          sel = 1'b0, wr = 1'b0;
    logic [4:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq_n, fiq_n;

    int checks = 0, fails = 0;

    // behavioural reference state, initialised to R1 reset values
    logic [TOT-1:0] m_mask = '1, m_route = '0;
    logic           m_sw = 1'b0;
    logic [31:0]    m_rdata = '0;
    logic           e_irq_n = 1'b1, e_fiq_n = 1'b1;

    always #4 clk = ~clk;

    dual_line_intc #(.NUM_SRC(N)) dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_sel(sel), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
        .irq_n(irq_n), .fiq_n(fiq_n)
    );

    always @(posedge clk) begin
        automatic bit norm = 0, fast = 0;
        automatic logic [TOT-1:0] st;
        if (!rst_n) begin
            m_mask <= '1; m_route <= '0; m_sw <= 0; m_rdata <= '0;
            e_irq_n <= 1; e_fiq_n <= 1;
        end else begin
            st = {m_sw, src};
            for (int i = 0; i < TOT; i++)
                if (st[i] && !m_mask[i]) begin
                    if (m_route[i]) fast = 1; else norm = 1;
                end
            e_irq_n <= !norm;
            e_fiq_n <= !fast;
            if (sel && !wr) begin
                if (addr == 5'h00)      m_rdata <= 32'(st);
                else if (addr == 5'h04) m_rdata <= 32'(m_mask);
                else if (addr == 5'h08) m_rdata <= 32'(m_route);
                else                    m_rdata <= 0;
            end else if (sel && wr) begin
                if (addr == 5'h04) m_mask <= wdata[TOT-1:0];
                if (addr == 5'h08) m_route <= wdata[TOT-1:0];
                if (addr == 5'h0C && wdata[0]) m_sw <= 1;
                if (addr == 5'h10 && wdata[0]) m_sw <= 0;
            end
        end
    end

    // R1 (during reset), R5, R6, R11 compared on every cycle
    always @(negedge clk) begin
        checks += 3;
        if (irq_n !== e_irq_n) begin
            fails++; $display("FAIL R5 irq_n act=%b exp=%b t=%0t", irq_n, e_irq_n, $time);
        end
        if (fiq_n !== e_fiq_n) begin
            fails++; $display("FAIL R6 fiq_n act=%b exp=%b t=%0t", fiq_n, e_fiq_n, $time);
        end
        if (rdata !== m_rdata) begin
            fails++; $display("FAIL R11 rdata act=%h exp=%h t=%0t", rdata, m_rdata, $time);
        end
    end

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk); sel = 0; wr = 0;
    endtask

    task automatic rd_reg(input logic [4:0] a);
        @(negedge clk); sel = 1; wr = 0; addr = a;
        @(negedge clk); sel = 0;
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;                               // R1 checked during reset
        rd_reg(5'h04);                           // R1 mask all ones
        src = 8'hA5; rd_reg(5'h00);              // R2 masked sources still visible
        wr_reg(5'h04, 32'h0);                    // R3 unmask all
        repeat (2) @(negedge clk);               // R5 normal line low
        wr_reg(5'h08, 32'h0F0); rd_reg(5'h08);   // R4 split routing
        wr_reg(5'h04, 32'h0F); repeat (2) @(negedge clk); // R3 mask low nibble
        src = 8'h00; repeat (2) @(negedge clk);  // R10 release
        wr_reg(5'h0C, 32'h0);  rd_reg(5'h00);    // R7 bit0=0 no effect
        wr_reg(5'h0C, 32'h1);  rd_reg(5'h00);    // R7 set
        wr_reg(5'h08, 32'h100); repeat (2) @(negedge clk); // R6 sw to fast line
        wr_reg(5'h10, 32'h0);  rd_reg(5'h00);    // R8 bit0=0 no effect
        wr_reg(5'h10, 32'h1);  rd_reg(5'h00);    // R8 clear
        wr_reg(5'h00, 32'hFFFF_FFFF); rd_reg(5'h04); rd_reg(5'h08); // R9
        wr_reg(5'h1C, 32'hFFFF_FFFF); rd_reg(5'h04); // R9 unmapped write
        rd_reg(5'h0C); rd_reg(5'h1C);            // R11 unmapped read zero
        for (int k = 0; k < 400; k++) begin
            automatic int pick = $urandom_range(0, 6);
            src = N'($urandom);
            case (pick)
                0: wr_reg(5'h04, $urandom);
                1: wr_reg(5'h08, $urandom);
                2: wr_reg(5'h0C, $urandom);
                3: wr_reg(5'h10, $urandom);
                4: rd_reg(5'(4 * $urandom_range(0, 7)));
                5: wr_reg(5'(4 * $urandom_range(0, 7)), $urandom);
                default: @(negedge clk);
            endcase
        end
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule